// File: doc/BRIEF.md
# Burst-Absorbing Line FIFO with Loss Evidence

This block sits between a line assembler and a packet framer. It takes pixels through a valid/ready write port that marks the first and last word of each line. It hands them on through a valid/ready read port. Each stored word carries the sequence number of the line it belongs to. A line is taken as a whole or not at all. When its first word arrives, the free space is compared with the configured line length. If the space is too small, every word of that line is consumed and thrown away, and a drop counter advances once. Words that arrive outside any line (no start marker while no line is open) are discarded without being counted.

To support diagnosis, the block keeps several pieces of evidence:
- an input-side line counter that advances on every line start, kept or dropped;
- the live fill level and a watermark comparison on it;
- the lowest and highest fill levels seen since reset or the last clear;
- sticky flags for a dropped line (overrun) and for a reader left waiting inside a line (underrun).

A downstream consumer compares the read-side sequence numbers with the drop counter. From that it can tell loss inside this buffer apart from loss further down the network path.

Top module: `line_guard_fifo`

## Requirements
- R1: After reset the fill level, floor, peak, line counter and drop counter are 0, both sticky flags are 0, and `rd_valid` is 0.
- R2: A line whose first word (`wr_sol`=1) sees free space (DEPTH minus level) at least `cfg_line_len` is stored in full. Its words come out in order, with `rd_sol` on the first word and `rd_eol` on the last.
- R3: A line whose first word sees less free space than `cfg_line_len` stores none of its words. `drop_cnt` advances by exactly one, and `wr_ready` stays 1 for every word of that line.
- R4: `line_cnt` advances by one on every accepted start word, whether the line is kept or dropped. Every word read out carries in `rd_seq` the value `line_cnt` had when its line started, so a dropped line shows as a gap in `rd_seq`.
- R5: `fill_level` equals the number of words stored, and `rd_valid` is 1 exactly when it is non-zero.
- R6: `wmark_hit` is 1 exactly when `fill_level` is at least `cfg_wmark`.
- R7: `fill_floor` and `fill_peak` hold the minimum and maximum of the level sampled at every clock since reset or the last `stat_clr`. A `stat_clr` loads both with the current level.
- R8: `ovr_flag` is set by any dropped line and stays set until `stat_clr`. A drop in the same cycle as the clear wins.
- R9: `udr_flag` is set when `rd_ready` is 1 and the buffer is empty while the reader is inside a line (a start word has been read and its end word has not). It is not set while the reader waits between lines, and it holds until `stat_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_line_len | input | LW | Words reserved per line at admission |
| cfg_wmark | input | LW | Watermark threshold on the fill level |
| stat_clr | input | 1 | Clears sticky flags, reloads floor and peak |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | Write word accepted |
| wr_data | input | DATA_W | Pixel word |
| wr_sol | input | 1 | First word of a line |
| wr_eol | input | 1 | Last word of a line |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Reader takes the word |
| rd_data | output | DATA_W | Pixel word |
| rd_sol | output | 1 | First word of a line |
| rd_eol | output | 1 | Last word of a line |
| rd_seq | output | SEQ_W | Sequence number of the word's line |
| fill_level | output | LW | Words currently stored |
| fill_floor | output | LW | Lowest level since clear |
| fill_peak | output | LW | Highest level since clear |
| wmark_hit | output | 1 | Level at or above the watermark |
| ovr_flag | output | 1 | Sticky: a line was dropped |
| udr_flag | output | 1 | Sticky: reader starved inside a line |
| line_cnt | output | SEQ_W | Line starts seen at the input |
| drop_cnt | output | CNT_W | Lines dropped whole |

## Verification
Two situations are hard to reach from the ports. The first is a drop with partial space: the buffer must hold some free words, but fewer than a line needs. The stimulus stalls the reader and stacks full lines plus one short line, leaving two free words, so the next line has to be refused even though it is not blocked by a full buffer. The second is an underrun. It needs the reader to overtake the writer inside a line. The stimulus reads continuously while the writer spaces its words several cycles apart, so the start word leaves before the rest arrive. The bench also checks the opposite case: an empty buffer between lines must leave the underrun flag clear.

// File: rtl/lgf_pkg.sv
package lgf_pkg;
  // Write-side line state
  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_KEEP = 2'd1,
    WR_DROP = 2'd2
  } wr_state_e;
endpackage

// File: rtl/lgf_store.sv
module lgf_store #(
  parameter int unsigned W     = 34,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_word,
  input  logic          pop,
  output logic [W-1:0]  pop_word,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LW-1:0] lvl_q, lvl_d;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    lvl_d  = lvl_q;
    if (push) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + AW'(1);
    if (pop)  rptr_d = (rptr_q == LAST) ? '0 : rptr_q + AW'(1);
    if (push && !pop)      lvl_d = lvl_q + LW'(1);
    else if (pop && !push) lvl_d = lvl_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= push_word;
  end

  assign pop_word = mem[rptr_q];
  assign level    = lvl_q;
  assign full     = (lvl_q == LW'(DEPTH));
  assign empty    = (lvl_q == '0);

  // R5
  push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R5
  level_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> level == $past(level) + LW'(1));
  // R5
  level_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> level == $past(level) - LW'(1));
endmodule

// File: rtl/lgf_admit.sv
module lgf_admit
  import lgf_pkg::*;
#(
  parameter int unsigned LW    = 7,
  parameter int unsigned SEQ_W = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             wr_sol,
  input  logic             wr_eol,
  output logic             wr_ready,
  input  logic [LW-1:0]    free,
  input  logic             full,
  input  logic [LW-1:0]    cfg_line_len,
  output logic             push,
  output logic [SEQ_W-1:0] push_seq,
  output logic             drop_evt,
  output logic [SEQ_W-1:0] line_cnt,
  output logic [CNT_W-1:0] drop_cnt
);
  wr_state_e        st_q, st_d;
  logic [SEQ_W-1:0] tag_q, tag_d, lcnt_q, lcnt_d;
  logic [CNT_W-1:0] dcnt_q, dcnt_d;
  logic             hs, start, fits;

  assign fits     = (free >= cfg_line_len) && !full;
  assign wr_ready = wr_sol ? 1'b1 : ((st_q == WR_KEEP) ? !full : 1'b1);
  assign hs       = wr_valid && wr_ready;
  assign start    = hs && wr_sol;
  assign drop_evt = start && !fits;
  assign push     = hs && (wr_sol ? fits : (st_q == WR_KEEP));
  assign push_seq = wr_sol ? lcnt_q : tag_q;

  always_comb begin
    st_d   = st_q;
    tag_d  = tag_q;
    lcnt_d = lcnt_q;
    dcnt_d = dcnt_q;
    if (start) begin
      tag_d  = lcnt_q;
      lcnt_d = lcnt_q + SEQ_W'(1);
      if (!fits) dcnt_d = dcnt_q + CNT_W'(1);
      if (wr_eol)    st_d = WR_IDLE;
      else if (fits) st_d = WR_KEEP;
      else           st_d = WR_DROP;
    end else if (hs && wr_eol) begin
      st_d = WR_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WR_IDLE;
      tag_q  <= '0;
      lcnt_q <= '0;
      dcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      tag_q  <= tag_d;
      lcnt_q <= lcnt_d;
      dcnt_q <= dcnt_d;
    end
  end

  assign line_cnt = lcnt_q;
  assign drop_cnt = dcnt_q;

  // R3
  drop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sol && (free < cfg_line_len)) |=> drop_cnt == $past(drop_cnt) + CNT_W'(1));
  // R3
  drop_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WR_DROP) |-> (wr_ready && !push));
  // R4
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sol) |=> line_cnt == $past(line_cnt) + SEQ_W'(1));
endmodule

// File: rtl/lgf_stats.sv
module lgf_stats #(
  parameter int unsigned LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] cfg_wmark,
  input  logic          clr,
  input  logic          drop_evt,
  input  logic          rd_ready,
  input  logic          rd_valid,
  input  logic          pop_sol,
  input  logic          pop_eol,
  output logic [LW-1:0] floor_lvl,
  output logic [LW-1:0] peak_lvl,
  output logic          wm_hit,
  output logic          ovr,
  output logic          udr
);
  logic [LW-1:0] floor_q, floor_d, peak_q, peak_d;
  logic          ovr_q, ovr_d, udr_q, udr_d, inl_q, inl_d;
  logic          pop;

  assign pop = rd_valid && rd_ready;

  always_comb begin
    floor_d = clr ? level : ((level < floor_q) ? level : floor_q);
    peak_d  = clr ? level : ((level > peak_q)  ? level : peak_q);
    ovr_d   = drop_evt || (ovr_q && !clr);
    udr_d   = (rd_ready && !rd_valid && inl_q) || (udr_q && !clr);
    inl_d   = inl_q;
    if (pop) inl_d = pop_eol ? 1'b0 : (pop_sol ? 1'b1 : inl_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      floor_q <= '0;
      peak_q  <= '0;
      ovr_q   <= 1'b0;
      udr_q   <= 1'b0;
      inl_q   <= 1'b0;
    end else begin
      floor_q <= floor_d;
      peak_q  <= peak_d;
      ovr_q   <= ovr_d;
      udr_q   <= udr_d;
      inl_q   <= inl_d;
    end
  end

  assign floor_lvl = floor_q;
  assign peak_lvl  = peak_q;
  assign wm_hit    = (level >= cfg_wmark);
  assign ovr       = ovr_q;
  assign udr       = udr_q;

  // R7
  floor_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    floor_q <= peak_q);
  // R8
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !clr) |=> ovr_q);
  // R9
  udr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (udr_q && !clr) |=> udr_q);
endmodule

// File: rtl/line_guard_fifo.sv
module line_guard_fifo #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned SEQ_W  = 16,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LW-1:0]     cfg_line_len,
  input  logic [LW-1:0]     cfg_wmark,
  input  logic              stat_clr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_sol,
  input  logic              wr_eol,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_sol,
  output logic              rd_eol,
  output logic [SEQ_W-1:0]  rd_seq,
  output logic [LW-1:0]     fill_level,
  output logic [LW-1:0]     fill_floor,
  output logic [LW-1:0]     fill_peak,
  output logic              wmark_hit,
  output logic              ovr_flag,
  output logic              udr_flag,
  output logic [SEQ_W-1:0]  line_cnt,
  output logic [CNT_W-1:0]  drop_cnt
);
  localparam int unsigned EW = DATA_W + SEQ_W + 2;

  logic [EW-1:0]    in_word, out_word;
  logic [LW-1:0]    level, free;
  logic             full, empty, push, pop, drop_evt;
  logic [SEQ_W-1:0] push_seq;

  assign free     = LW'(DEPTH) - level;
  assign in_word  = {wr_sol, wr_eol, push_seq, wr_data};
  assign rd_valid = !empty;
  assign pop      = rd_valid && rd_ready;
  assign {rd_sol, rd_eol, rd_seq, rd_data} = out_word;

  lgf_admit #(.LW(LW), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_admit (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sol(wr_sol),
    .wr_eol(wr_eol), .wr_ready(wr_ready), .free(free), .full(full),
    .cfg_line_len(cfg_line_len), .push(push), .push_seq(push_seq),
    .drop_evt(drop_evt), .line_cnt(line_cnt), .drop_cnt(drop_cnt)
  );

  lgf_store #(.W(EW), .DEPTH(DEPTH), .LW(LW)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .push_word(in_word),
    .pop(pop), .pop_word(out_word), .level(level), .full(full),
    .empty(empty)
  );

  lgf_stats #(.LW(LW)) u_stats (
    .clk(clk), .rst_n(rst_n), .level(level), .cfg_wmark(cfg_wmark),
    .clr(stat_clr), .drop_evt(drop_evt), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .pop_sol(rd_sol), .pop_eol(rd_eol),
    .floor_lvl(fill_floor), .peak_lvl(fill_peak), .wm_hit(wmark_hit),
    .ovr(ovr_flag), .udr(udr_flag)
  );

  assign fill_level = level;

  // R2
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !rd_eol) |=> (rd_valid |-> (rd_sol || rd_seq == $past(rd_seq))));
endmodule

// File: tb/line_guard_fifo_test.sv
module line_guard_fifo_test;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 16;
  localparam int SEQ_W  = 16;
  localparam int CNT_W  = 16;
  localparam int LW     = $clog2(DEPTH + 1);
  localparam int XW     = DATA_W + SEQ_W + 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [LW-1:0] cfg_line_len, cfg_wmark;
  logic stat_clr, wr_valid, wr_sol, wr_eol, rd_ready;
  logic [DATA_W-1:0] wr_data;
  logic wr_ready, rd_valid, rd_sol, rd_eol, wmark_hit, ovr_flag, udr_flag;
  logic [DATA_W-1:0] rd_data;
  logic [SEQ_W-1:0] rd_seq, line_cnt;
  logic [LW-1:0] fill_level, fill_floor, fill_peak;
  logic [CNT_W-1:0] drop_cnt;

  int checks = 0;
  int errors = 0;
  int seq_model = 0;
  logic [XW-1:0] sb[$];

  always #2 clk = ~clk;

  line_guard_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_line_len(cfg_line_len), .cfg_wmark(cfg_wmark),
    .stat_clr(stat_clr), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .wr_sol(wr_sol), .wr_eol(wr_eol), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_sol(rd_sol), .rd_eol(rd_eol), .rd_seq(rd_seq),
    .fill_level(fill_level), .fill_floor(fill_floor), .fill_peak(fill_peak),
    .wmark_hit(wmark_hit), .ovr_flag(ovr_flag), .udr_flag(udr_flag),
    .line_cnt(line_cnt), .drop_cnt(drop_cnt)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: compares each transferred word with the scoreboard (R2, R4)
  always begin
    @(negedge clk); #1;
    if (rst_n && rd_valid && rd_ready) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R2 actual=%0d expected=%0d (unexpected word)", rd_data, 0);
      end else begin
        logic [XW-1:0] e;
        e = sb.pop_front();
        if ({rd_sol, rd_eol, rd_seq, rd_data} !== e) begin
          errors++;
          $display("FAIL R2/R4 actual=%0h expected=%0h", {rd_sol, rd_eol, rd_seq, rd_data}, e);
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    wr_valid = 1'b0; wr_sol = 1'b0; wr_eol = 1'b0;
    #1;
  endtask

  // Driver: sends one line; kept lines are pushed to the scoreboard
  task automatic send_line(int n, int gap, bit keep);
    int waits = 0;
    for (int i = 0; i < n; i++) begin
      logic [DATA_W-1:0] d;
      d = DATA_W'((seq_model << 8) | i);
      if (keep) sb.push_back({(i == 0), (i == n - 1), SEQ_W'(seq_model), d});
      @(negedge clk);
      wr_valid = 1'b1; wr_sol = (i == 0); wr_eol = (i == n - 1); wr_data = d;
      #1;
      while (!wr_ready) begin @(negedge clk); #1; waits++; end
      if (gap > 0) begin
        @(negedge clk);
        wr_valid = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    seq_model++;
    if (!keep) chk("R3 wr_ready stall cycles in dropped line", 32'(waits), 0);
    idle(1);
  endtask

  task automatic drain();
    int t = 0;
    @(negedge clk); rd_ready = 1'b1;
    while ((sb.size() != 0 || fill_level != 0) && t < 500) begin @(negedge clk); t++; end
    idle(3);
  endtask

  task automatic pulse_clr();
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
    idle(1);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; stat_clr = 1'b0; wr_valid = 1'b0; wr_sol = 1'b0; wr_eol = 1'b0;
    wr_data = '0; rd_ready = 1'b0;
    cfg_line_len = LW'(4); cfg_wmark = LW'(8);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 fill_level", 32'(fill_level), 0);
    chk("R1 fill_floor", 32'(fill_floor), 0);
    chk("R1 fill_peak", 32'(fill_peak), 0);
    chk("R1 line_cnt", 32'(line_cnt), 0);
    chk("R1 drop_cnt", 32'(drop_cnt), 0);
    chk("R1 flags", {30'd0, ovr_flag, udr_flag}, 0);
    chk("R1 rd_valid", 32'(rd_valid), 0);

    // Reader stalled: build up level
    send_line(4, 0, 1'b1);
    idle(2);
    chk("R5 level after one line", 32'(fill_level), 4);
    chk("R5 rd_valid with data", 32'(rd_valid), 1);
    chk("R6 below watermark", 32'(wmark_hit), 0);
    send_line(4, 0, 1'b1);
    send_line(4, 1, 1'b1);
    idle(2);
    chk("R5 level after three lines", 32'(fill_level), 12);
    chk("R6 above watermark", 32'(wmark_hit), 1);
    cfg_wmark = LW'(12); #1;
    chk("R6 equal to watermark", 32'(wmark_hit), 1);
    cfg_wmark = LW'(13); #1;
    chk("R6 one below watermark", 32'(wmark_hit), 0);
    chk("R7 peak", 32'(fill_peak), 12);
    chk("R7 floor", 32'(fill_floor), 0);

    // Exact fit then full-buffer drop
    send_line(4, 0, 1'b1);
    send_line(4, 0, 1'b0);
    idle(2);
    chk("R2 exact fit level", 32'(fill_level), 16);
    chk("R3 drop_cnt after full drop", 32'(drop_cnt), 1);
    chk("R3 level unchanged by drop", 32'(fill_level), 16);
    chk("R4 line_cnt counts dropped line", 32'(line_cnt), 5);
    chk("R8 overrun set", 32'(ovr_flag), 1);

    pulse_clr();
    chk("R8 overrun cleared", 32'(ovr_flag), 0);
    chk("R7 floor reload on clear", 32'(fill_floor), 16);
    chk("R7 peak reload on clear", 32'(fill_peak), 16);

    // Drain: seq 0..3 expected, seq 4 missing
    drain();
    chk("R5 empty after drain", 32'(fill_level), 0);
    chk("R5 rd_valid empty", 32'(rd_valid), 0);
    chk("R7 floor after drain", 32'(fill_floor), 0);
    chk("R7 peak after drain", 32'(fill_peak), 16);
    chk("R9 no underrun between lines", 32'(udr_flag), 0);

    // Underrun: reader overtakes a slow writer inside a line
    send_line(4, 4, 1'b1);
    idle(3);
    chk("R9 underrun inside line", 32'(udr_flag), 1);
    chk("R2 slow line fully read", 32'(sb.size()), 0);
    pulse_clr();
    chk("R9 underrun cleared", 32'(udr_flag), 0);

    // Partial-space drop
    @(negedge clk); rd_ready = 1'b0;
    send_line(4, 0, 1'b1);
    send_line(4, 0, 1'b1);
    send_line(4, 0, 1'b1);
    send_line(2, 0, 1'b1);
    idle(2);
    chk("R5 level with short line", 32'(fill_level), 14);
    send_line(4, 0, 1'b0);
    idle(2);
    chk("R3 partial-space drop count", 32'(drop_cnt), 2);
    chk("R3 partial-space level", 32'(fill_level), 14);
    chk("R4 line_cnt total", 32'(line_cnt), 11);
    chk("R8 overrun set again", 32'(ovr_flag), 1);
    pulse_clr();
    chk("R7 clear at 14 floor", 32'(fill_floor), 14);
    chk("R7 clear at 14 peak", 32'(fill_peak), 14);
    drain();
    chk("R2 scoreboard empty", 32'(sb.size()), 0);
    chk("R7 floor after final drain", 32'(fill_floor), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule